// File: doc/BRIEF.md
# RTC Interrupt Emulation Engine

This block recreates the three interrupt sources of a real-time clock: the once-per-second update event, the time-of-day alarm and the programmable periodic interrupt. It uses only a fast free-running counter that it does not own and a single comparator channel that it keeps internally. The comparator is reloaded in steps. The default step is one sixty-fourth of a second of counter ticks. When a periodic rate faster than 64 Hz is requested, the step becomes one period of that rate. Rates at or below 64 Hz come from a divider running on the 64 Hz base tick.

When the counter reaches the comparator, the engine services the deadline. It advances the comparator one step per clock until the comparator is no longer behind the counter. Every advance beyond the first counts as a lost tick, and lost ticks feed the periodic divider. The engine then compares the current time-of-day with the last recorded second and with the alarm setting. It publishes a status word and a one-cycle interrupt pulse. Time-of-day keeping and register access sit outside the block. The outputs are plain control pins with no handshake: the word is meaningful in the cycle the pulse is high, and it holds its value until the next pulse.

Top module: `rtc_irq_emu`

## Requirements
- R1: After reset, irq_pulse is 0, irq_word is 0, and no service takes place until some interrupt type is enabled.
- R2: When any enable rises from the all-disabled state, the comparator is loaded at that clock edge with counter + step. A service starts at the first edge where counter − comparator, taken as a signed 32-bit value, is ≥ 0, and no earlier.
- R3: rate_code k selects a periodic rate of 2^k Hz and is clamped to 1..13. When periodic is enabled and k > 6, the step is DEF_STEP >> (k−6). In every other case the step is DEF_STEP.
- R4: A service first advances the comparator by one step. It then keeps advancing by one step per clock while the counter is strictly ahead of it (signed 32-bit difference > 0). lost = the number of extra advances. With the counter held, the pulse is high in the cycle after edge hit+lost+1.
- R5: The divide limit is 2^(6−k) for k ≤ 6 and 1 otherwise. At each service with periodic enabled, count + lost + 1 is formed. If that value is ≥ limit, the periodic flag (bit 6) is set and the count returns to 0. Otherwise the count takes that value. The count is held at 0 while periodic is disabled.
- R6: The update flag (bit 4) is set at a service when update is enabled and tod_sec differs from the recorded second. The recorded second (0 after reset) then takes tod_sec.
- R7: The alarm flag (bit 5) is set at a service only when alarm is enabled and hours, minutes and seconds all equal the alarm inputs.
- R8: When any flag is set, irq_word becomes {8'd1, pending bit 7 = 1, bit 6 periodic, bit 5 alarm, bit 4 update, 4'b0}. irq_word does not change in any other cycle.
- R9: irq_pulse is high for exactly one cycle per service that sets a flag. A service with no flag gives no pulse but still advances the comparator.
- R10: While all enables are low the channel is off and produces no pulses, whatever the counter does. Re-enabling re-arms as in R2.
- R11: All comparisons are modulo 2^32, so a deadline that wraps past zero is serviced correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| counter | input | 32 | Free-running time base |
| upd_en | input | 1 | Update interrupt enable |
| alm_en | input | 1 | Alarm interrupt enable |
| per_en | input | 1 | Periodic interrupt enable |
| rate_code | input | 4 | Periodic rate exponent (2^k Hz) |
| alm_hr | input | 5 | Alarm hours |
| alm_min | input | 6 | Alarm minutes |
| alm_sec | input | 6 | Alarm seconds |
| tod_hr | input | 5 | Current hours |
| tod_min | input | 6 | Current minutes |
| tod_sec | input | 6 | Current seconds |
| irq_word | output | 16 | Interrupt status word |
| irq_pulse | output | 1 | One-cycle interrupt strobe |

## Verification
A wrong comparator value shows up at the very next deadline: the pulse arrives a cycle or more early or late relative to the counter value that should trigger it. A wrong lost-tick count or divider state stays hidden until a later service, where the periodic bit appears at the wrong service. A stale recorded second shows as a missing or extra update bit at the next service. The bench places the counter exactly one tick before and exactly on each predicted deadline, and it samples the pulse in the single cycle the catch-up depth predicts, so each of these faults is caught within one service of its cause.

// File: rtl/rtc_emu_pkg.sv
package rtc_emu_pkg;
  localparam int FLG_UPD  = 4;
  localparam int FLG_ALM  = 5;
  localparam int FLG_PER  = 6;
  localparam int FLG_PEND = 7;

  typedef struct packed {
    logic [4:0] hr;
    logic [5:0] mn;
    logic [5:0] sc;
  } hms_t;

  typedef enum logic [1:0] {CH_OFF, CH_ARMED, CH_CATCH} ch_state_e;
endpackage

// File: rtl/rtc_step_sel.sv
module rtc_step_sel #(
  parameter int CNT_W     = 32,
  parameter int DEF_STEP  = 1024,
  parameter int BASE_LOG2 = 6,
  parameter int MAX_LOG2  = 13,
  parameter int LIM_W     = 6
) (
  input  logic [3:0]       rate_code,
  input  logic             per_en,
  output logic [CNT_W-1:0] step,
  output logic [LIM_W-1:0] limit
);
  localparam logic [CNT_W-1:0] DEF_V = CNT_W'(DEF_STEP);
  localparam logic [3:0]       BASE  = 4'(BASE_LOG2);
  localparam logic [3:0]       KMAX  = 4'(MAX_LOG2);

  logic [3:0] k;

  always_comb begin
    k = rate_code;
    if (k < 4'd1) k = 4'd1;
    if (k > KMAX) k = KMAX;
    if (per_en && k > BASE) step = DEF_V >> (k - BASE);
    else                    step = DEF_V;
    if (k <= BASE) limit = LIM_W'(1) << (BASE - k);
    else           limit = LIM_W'(1);
  end
endmodule

// File: rtl/rtc_cmp_ctl.sv
module rtc_cmp_ctl
  import rtc_emu_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int LOST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  counter,
  input  logic [CNT_W-1:0]  step,
  input  logic              any_en,
  output logic              done,
  output logic [LOST_W-1:0] lost
);
  ch_state_e        st_q;
  logic [CNT_W-1:0] cmp_q;
  logic [LOST_W-1:0] lost_q;
  logic [CNT_W-1:0] diff;
  logic             reached, behind;

  always_comb begin
    diff    = counter - cmp_q;
    reached = !diff[CNT_W-1];
    behind  = reached && (diff != '0);
    done    = any_en && (st_q == CH_CATCH) && !behind;
    lost    = lost_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= CH_OFF;
      cmp_q  <= '0;
      lost_q <= '0;
    end else if (!any_en) begin
      st_q <= CH_OFF;
    end else begin
      case (st_q)
        CH_OFF: begin
          cmp_q <= counter + step;
          st_q  <= CH_ARMED;
        end
        CH_ARMED: if (reached) begin
          cmp_q  <= cmp_q + step;
          lost_q <= '0;
          st_q   <= CH_CATCH;
        end
        CH_CATCH: if (behind) begin
          cmp_q <= cmp_q + step;
          if (lost_q != '1) lost_q <= lost_q + 1'b1;
        end else begin
          st_q <= CH_ARMED;
        end
        default: st_q <= CH_OFF;
      endcase
    end
  end

  // R10: with nothing enabled the channel drops to off
  a_r10_off_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !any_en |=> st_q == CH_OFF);
  // R2: arming loads counter + step
  a_r2_arm_load: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CH_OFF && any_en) |=> cmp_q == $past(counter + step));
  // R4: each catch-up cycle advances by exactly one step
  a_r4_catchup_step: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CH_CATCH && any_en && behind) |=> cmp_q == $past(cmp_q + step));
  // R3: a zero step would never catch up
  a_r3_step_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    any_en |-> step != '0);
  // R9: services never complete back to back
  a_r9_no_double_service: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/rtc_flag_gen.sv
module rtc_flag_gen
  import rtc_emu_pkg::*;
#(
  parameter int LOST_W = 8,
  parameter int LIM_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic [LOST_W-1:0] lost,
  input  logic              upd_en,
  input  logic              alm_en,
  input  logic              per_en,
  input  logic [LIM_W-1:0]  limit,
  input  hms_t              tod,
  input  hms_t              alarm,
  output logic [15:0]       word,
  output logic              pulse
);
  localparam int CW = LOST_W + 1;

  logic [CW-1:0] pie_q, pie_nx;
  logic [5:0]    prev_q;
  logic          f_upd, f_alm, f_per, f_any;
  logic [15:0]   word_q;
  logic          pulse_q;

  always_comb begin
    pie_nx = pie_q + CW'(lost) + CW'(1);
    f_per  = per_en && (pie_nx >= CW'(limit));
    f_upd  = upd_en && (tod.sc != prev_q);
    f_alm  = alm_en && (tod == alarm);
    f_any  = f_per || f_upd || f_alm;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pie_q   <= '0;
      prev_q  <= '0;
      word_q  <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= done && f_any;
      if (!per_en)   pie_q <= '0;
      else if (done) pie_q <= f_per ? '0 : pie_nx;
      if (done && f_upd) prev_q <= tod.sc;
      if (done && f_any) begin
        word_q           <= '0;
        word_q[15:8]     <= 8'd1;
        word_q[FLG_PEND] <= 1'b1;
        word_q[FLG_PER]  <= f_per;
        word_q[FLG_ALM]  <= f_alm;
        word_q[FLG_UPD]  <= f_upd;
      end
    end
  end

  assign word  = word_q;
  assign pulse = pulse_q;

  // R9: strobe lasts one cycle
  a_r9_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q);
  // R8: a pulse always carries pending, a count of one and some cause
  a_r8_word_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> (word_q[15:8] == 8'd1 && word_q[FLG_PEND] && word_q[6:4] != 3'b0));
  // R8: word changes only together with a pulse
  a_r8_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pulse_q |-> $stable(word_q));
  // R5: count is zero whenever periodic is off
  a_r5_count_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(per_en) |-> pie_q == '0);
endmodule

// File: rtl/rtc_irq_emu.sv
module rtc_irq_emu
  import rtc_emu_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int DEF_STEP = 1024,
  parameter int LOST_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] counter,
  input  logic             upd_en,
  input  logic             alm_en,
  input  logic             per_en,
  input  logic [3:0]       rate_code,
  input  logic [4:0]       alm_hr,
  input  logic [5:0]       alm_min,
  input  logic [5:0]       alm_sec,
  input  logic [4:0]       tod_hr,
  input  logic [5:0]       tod_min,
  input  logic [5:0]       tod_sec,
  output logic [15:0]      irq_word,
  output logic             irq_pulse
);
  localparam int BASE_LOG2 = 6;
  localparam int LIM_W     = BASE_LOG2;

  logic [CNT_W-1:0]  step;
  logic [LIM_W-1:0]  limit;
  logic              done;
  logic [LOST_W-1:0] lost;
  logic              any_en;
  hms_t              tod, alarm;

  assign any_en = upd_en | alm_en | per_en;
  assign tod    = '{hr: tod_hr, mn: tod_min, sc: tod_sec};
  assign alarm  = '{hr: alm_hr, mn: alm_min, sc: alm_sec};

  rtc_step_sel #(.CNT_W(CNT_W), .DEF_STEP(DEF_STEP), .BASE_LOG2(BASE_LOG2),
                 .MAX_LOG2(13), .LIM_W(LIM_W)) u_step (
    .rate_code(rate_code), .per_en(per_en), .step(step), .limit(limit));

  rtc_cmp_ctl #(.CNT_W(CNT_W), .LOST_W(LOST_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .counter(counter), .step(step),
    .any_en(any_en), .done(done), .lost(lost));

  rtc_flag_gen #(.LOST_W(LOST_W), .LIM_W(LIM_W)) u_flag (
    .clk(clk), .rst_n(rst_n), .done(done), .lost(lost),
    .upd_en(upd_en), .alm_en(alm_en), .per_en(per_en), .limit(limit),
    .tod(tod), .alarm(alarm), .word(irq_word), .pulse(irq_pulse));
endmodule

// File: tb/test_rtc_irq_emu.sv
module test_rtc_irq_emu;
  localparam int DEF = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] counter = '0;
  logic        upd_en = 0, alm_en = 0, per_en = 0;
  logic [3:0]  rate_code = 4'd6;
  logic [4:0]  alm_hr = '0, tod_hr = '0;
  logic [5:0]  alm_min = '0, alm_sec = '0, tod_min = '0, tod_sec = '0;
  logic [15:0] irq_word;
  logic        irq_pulse;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [31:0] exp_cmp;
  int pie = 0, prev = 0;

  always #5 clk = ~clk;

  rtc_irq_emu #(.DEF_STEP(DEF)) i_rtc_irq_emu (
    .clk(clk), .rst_n(rst_n), .counter(counter), .upd_en(upd_en), .alm_en(alm_en),
    .per_en(per_en), .rate_code(rate_code), .alm_hr(alm_hr), .alm_min(alm_min),
    .alm_sec(alm_sec), .tod_hr(tod_hr), .tod_min(tod_min), .tod_sec(tod_sec),
    .irq_word(irq_word), .irq_pulse(irq_pulse));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int kc(int rc);
    return rc < 1 ? 1 : (rc > 13 ? 13 : rc);
  endfunction
  function automatic logic [31:0] step_f();
    int k = kc(int'(rate_code));
    if (per_en && k > 6) return 32'(DEF >> (k - 6));
    return 32'(DEF);
  endfunction
  function automatic int lim_f();
    int k = kc(int'(rate_code));
    return k <= 6 ? (1 << (6 - k)) : 1;
  endfunction

  // arm from all-disabled (R2)
  task automatic arm(input logic [31:0] v0, input bit u, input bit a, input bit p);
    @(negedge clk);
    counter = v0; upd_en = u; alm_en = a; per_en = p;
    if (!p) pie = 0;
    @(negedge clk);
    exp_cmp = v0 + step_f();
  endtask

  task automatic quiet(input logic [31:0] v, input int n, input string req);
    bit ok = 1;
    @(negedge clk);
    counter = v;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (irq_pulse) ok = 0;
    end
    chk(ok, req, {31'b0, ~ok}, 32'd0);
  endtask

  task automatic service(input logic [31:0] v, input string req);
    logic [31:0] s, c, ew;
    int lost, nx;
    bit fp, fu, fa, ep;
    s = step_f(); c = exp_cmp + s; lost = 0;
    while ($signed(v - c) > 0) begin c += s; lost++; end
    exp_cmp = c;
    fp = 0;
    if (per_en) begin
      nx = pie + lost + 1;
      if (nx >= lim_f()) begin fp = 1; pie = 0; end else pie = nx;
    end else pie = 0;
    fu = upd_en && (int'(tod_sec) != prev);
    if (fu) prev = int'(tod_sec);
    fa = alm_en && tod_hr == alm_hr && tod_min == alm_min && tod_sec == alm_sec;
    ep = fp | fu | fa;
    ew = {16'd0, 8'd1, 1'b1, fp, fa, fu, 4'd0};
    @(negedge clk);
    counter = v;
    repeat (lost + 2) @(negedge clk);
    chk(irq_pulse == ep, {req, " pulse"}, {31'b0, irq_pulse}, {31'b0, ep});
    if (ep) chk(irq_word == ew[15:0], {req, " word"}, {16'd0, irq_word}, ew);
    @(negedge clk);
    chk(!irq_pulse, "R9 pulse width", {31'b0, irq_pulse}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    process::self().srandom(32'd20240611);
    repeat (3) @(negedge clk);
    chk(!irq_pulse && irq_word == 16'd0, "R1 reset state", {15'd0, irq_pulse, irq_word}, 32'd0);
    rst_n = 1'b1;
    quiet(32'h0000_5000, 6, "R1 idle after reset");

    // R2 / R6 / R8: update only
    tod_sec = 6'd5;
    arm(32'h0000_1000, 1, 0, 0);
    quiet(exp_cmp - 1, 4, "R2 no early service");
    service(exp_cmp, "R2 R6 R8 update at deadline");
    // R9: same second -> silent service, comparator still advances
    service(exp_cmp + 32'd5, "R9 silent service");
    quiet(exp_cmp - 1, 4, "R9 comparator advanced");

    // R4 / R5: periodic 16 Hz, limit 4, three lost ticks
    @(negedge clk); per_en = 1; rate_code = 4'd4;
    service(exp_cmp + 3 * step_f() + 1, "R4 R5 catch-up feeds divider");
    service(exp_cmp + 1, "R5 divider below limit");

    // R7: alarm match and gating
    @(negedge clk); per_en = 0; pie = 0; alm_en = 1;
    alm_hr = 5'd7; alm_min = 6'd30; alm_sec = 6'd9;
    tod_hr = 5'd7; tod_min = 6'd30; tod_sec = 6'd9;
    service(exp_cmp, "R7 alarm match");
    @(negedge clk); alm_en = 0; tod_sec = 6'd9;
    upd_en = 1;
    @(negedge clk); tod_sec = 6'd10;
    service(exp_cmp, "R7 alarm gated off");

    // R3: 512 Hz step
    @(negedge clk); per_en = 1; rate_code = 4'd9;
    service(exp_cmp, "R3 fast rate service");
    quiet(exp_cmp - 1, 4, "R3 fast step not early");
    service(exp_cmp, "R3 fast step deadline");
    @(negedge clk); rate_code = 4'd15;
    service(exp_cmp + 1, "R3 clamp high");

    // R10: disabled channel ignores counter
    @(negedge clk); upd_en = 0; alm_en = 0; per_en = 0; pie = 0;
    quiet(exp_cmp + 32'd5000, 10, "R10 off no pulse");

    // R11: wrap past zero
    tod_sec = 6'd20;
    arm(32'hFFFF_FFC0, 1, 0, 0);
    quiet(exp_cmp - 1, 4, "R11 wrap no early");
    service(exp_cmp, "R11 wrap service");

    // random mix
    for (int it = 0; it < 40; it++) begin
      @(negedge clk);
      upd_en = 1'($urandom_range(0, 1));
      alm_en = 1'($urandom_range(0, 1));
      per_en = 1'($urandom_range(0, 1));
      if (!(upd_en | alm_en | per_en)) upd_en = 1;
      if (!per_en) pie = 0;
      rate_code = 4'($urandom_range(1, 13));
      tod_hr = 5'($urandom_range(0, 23));
      tod_min = 6'($urandom_range(0, 59));
      tod_sec = 6'($urandom_range(0, 3));
      if ($urandom_range(0, 2) == 0) begin
        alm_hr = tod_hr; alm_min = tod_min; alm_sec = tod_sec;
      end else alm_sec = 6'd61;
      v = exp_cmp;
      if ($urandom_range(0, 3) != 0)
        v = exp_cmp + 32'($urandom_range(0, 3)) * step_f() + 32'($urandom_range(1, int'(step_f()) - 1));
      service(v, "R4 R5 R6 R7 random");
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule